// File: doc/BRIEF.md
# SIMD Load Return Queue

This block sits between the memory hierarchy and the memory stage of a SIMD load/store/permute pipeline. When the pipeline issues a load, the block reserves one of twelve buffer slots and hands back that slot number as a tag. The memory system later returns a 128-bit beat carrying that tag and a bit naming the cache level that supplied it. The beat is written straight into its reserved slot, so returns may arrive in any order. The consuming stage removes entries strictly in the order they were reserved.

At most eight loads may be in flight at once. A load needs a free slot and a free in-flight credit in the same cycle. The credit comes back when the data arrives, and the slot is released when the consumer takes the entry. Whenever the consumer asks for data that has not yet arrived at the head slot, the block raises a stall in that same cycle.

A flush empties the queue. A load still in flight at flush time keeps its credit and its slot until its data returns, and that data is thrown away. Cache behaviour and address generation live elsewhere.

Top module: `ldq_stream`

## Requirements
- R1: After reset, `req_ready` is 1, nothing is in flight, `out_valid` is 0, and a consumer request stalls because the queue is empty.
- R2: Accepted requests (`req_valid` and `req_ready` in the same cycle) receive tags 0, 1, ..., 11, 0, ... in order, shown on `req_tag` in the accepting cycle.
- R3: No more than 8 requests are in flight. With 8 in flight, `req_ready` is 0. It returns to 1 in the cycle after a return for an in-flight tag.
- R4: With 12 entries reserved and not yet consumed, `req_ready` is 0 even when credits are free. It returns to 1 in the cycle after a pop.
- R5: A return writes the slot named by `ret_tag`, whatever the order of arrival. Pops deliver entries in reservation order.
- R6: In a cycle where `cons_req` is 1 and the head slot holds no returned data, `stall` is 1 in that same cycle and no entry is removed.
- R7: In a cycle where `cons_req` is 1 and the head slot holds data, the entry is removed. In the next cycle `out_valid` is 1 for one cycle with the returned `out_data` and `out_src` (0 = first-level cache, 1 = second-level cache).
- R8: A return beat is accepted on every cycle, so back-to-back returns on consecutive cycles are all stored.
- R9: In a cycle with `flush` at 1, `req_ready` is 0 and no pop occurs. Afterwards the queue is empty, and any previously returned data that was not consumed is discarded.
- R10: A return for a tag that was in flight at a flush frees its credit, and its data is never delivered. That slot cannot be reserved again until that return has arrived.
- R11: A return whose tag has no request in flight is ignored. It frees no credit and stores no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue and marks in-flight loads as stale |
| req_valid | input | 1 | Load request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_tag | output | TAG_W (4) | Slot reserved for a request accepted this cycle |
| ret_valid | input | 1 | Returned data beat present |
| ret_tag | input | TAG_W (4) | Slot the beat belongs to |
| ret_src | input | 1 | Supplying cache level: 0 first, 1 second |
| ret_data | input | DATA_W (128) | Returned beat |
| cons_req | input | 1 | Consumer stage needs the head entry |
| stall | output | 1 | Head entry not yet returned while requested |
| out_valid | output | 1 | Popped entry presented this cycle |
| out_src | output | 1 | Cache level of the popped entry |
| out_data | output | DATA_W (128) | Popped data |

## Verification
`req_ready`, `req_tag` and `stall` follow the inputs and registered state within the same cycle. The bench drives each stimulus on a falling edge and reads these three outputs one time step later. Returns and reservations change `req_ready` only from the next cycle, and a pop shows `out_valid`, `out_data` and `out_src` after the following rising edge. Each task therefore waits for exactly that edge and samples one time step after it, and the stale-return, credit and capacity checks each look at `req_ready` in the first cycle after the event that should change it.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  // Which cache level supplied a returned beat
  typedef enum logic {
    SRC_NEAR = 1'b0,
    SRC_FAR  = 1'b1
  } ldq_src_e;

endpackage

// File: rtl/ldq_credit.sv
// In-flight transaction credit counter
module ldq_credit #(
  parameter int CREDITS = 8,
  localparam int CNT_W = $clog2(CREDITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  output logic             has_credit,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({take, give})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign has_credit = (cnt < CNT_W'(CREDITS));

endmodule

// File: rtl/ldq_slot_ctl.sv
// Per-slot reserve / fill / stale tracking with ring pointers
module ldq_slot_ctl #(
  parameter int DEPTH = 12,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_fire,
  input  logic             pop_fire,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  output logic [TAG_W-1:0] wr_ptr,
  output logic [TAG_W-1:0] rd_ptr,
  output logic             wr_busy,
  output logic             head_filled,
  output logic             ret_live,
  output logic             ret_credit
);

  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [DEPTH-1:0] busy_v;
  logic [DEPTH-1:0] fill_v;
  logic [DEPTH-1:0] live_v;
  logic [DEPTH-1:0] cred_v;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic res_q, fill_q, stale_q;
      logic is_wr, is_rd, hit, pend;

      assign is_wr = (wr_ptr == TAG_W'(i));
      assign is_rd = (rd_ptr == TAG_W'(i));
      assign hit   = ret_valid && (ret_tag == TAG_W'(i));
      assign pend  = res_q && !fill_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          res_q   <= 1'b0;
          fill_q  <= 1'b0;
          stale_q <= 1'b0;
        end else if (flush) begin
          res_q   <= 1'b0;
          fill_q  <= 1'b0;
          stale_q <= (stale_q || pend) && !hit;
        end else begin
          if (alloc_fire && is_wr) begin
            res_q  <= 1'b1;
            fill_q <= 1'b0;
          end
          if (hit && pend) fill_q <= 1'b1;
          if (pop_fire && is_rd) begin
            res_q  <= 1'b0;
            fill_q <= 1'b0;
          end
          if (hit && stale_q) stale_q <= 1'b0;
        end
      end

      assign busy_v[i] = res_q || stale_q;
      assign fill_v[i] = fill_q;
      assign live_v[i] = hit && pend && !flush;
      assign cred_v[i] = hit && (pend || stale_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (alloc_fire)
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + TAG_W'(1);
      if (flush)
        rd_ptr <= wr_ptr;
      else if (pop_fire)
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + TAG_W'(1);
    end
  end

  assign wr_busy     = busy_v[wr_ptr];
  assign head_filled = fill_v[rd_ptr];
  assign ret_live    = |live_v;
  assign ret_credit  = |cred_v;

endmodule

// File: rtl/ldq_store.sv
// Entry storage: one write port, one registered read port
module ldq_store #(
  parameter int DEPTH = 12,
  parameter int WORD_W = 129,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TAG_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [TAG_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ldq_stream.sv
// Streaming load return queue (top)
module ldq_stream
  import ldq_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int CREDITS = 8,
  parameter int DATA_W = 128,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              ret_src,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              cons_req,
  output logic              stall,
  output logic              out_valid,
  output logic              out_src,
  output logic [DATA_W-1:0] out_data
);

  localparam int WORD_W = DATA_W + 1;

  logic             has_credit;
  logic [CNT_W-1:0] inflight;
  logic [TAG_W-1:0] wr_ptr, rd_ptr;
  logic             wr_busy, head_filled;
  logic             ret_live, ret_credit;
  logic             alloc_fire, pop_fire;
  ldq_src_e         wr_src;
  logic [WORD_W-1:0] rd_word;

  assign req_ready  = !flush && has_credit && !wr_busy;
  assign alloc_fire = req_valid && req_ready;
  assign req_tag    = wr_ptr;
  assign stall      = cons_req && !head_filled;
  assign pop_fire   = cons_req && head_filled && !flush;
  assign wr_src     = ldq_src_e'(ret_src);

  ldq_credit #(.CREDITS(CREDITS)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .take       (alloc_fire),
    .give       (ret_credit),
    .has_credit (has_credit),
    .cnt        (inflight)
  );

  ldq_slot_ctl #(.DEPTH(DEPTH)) u_slots (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .alloc_fire  (alloc_fire),
    .pop_fire    (pop_fire),
    .ret_valid   (ret_valid),
    .ret_tag     (ret_tag),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .wr_busy     (wr_busy),
    .head_filled (head_filled),
    .ret_live    (ret_live),
    .ret_credit  (ret_credit)
  );

  ldq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (ret_live),
    .waddr (ret_tag),
    .wdata ({wr_src, ret_data}),
    .re    (pop_fire),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= pop_fire;
  end

  assign out_src  = rd_word[WORD_W-1];
  assign out_data = rd_word[DATA_W-1:0];

endmodule

// File: rtl/ldq_stream_chk.sv
// Property checker for ldq_stream
module ldq_stream_chk #(
  parameter int DEPTH = 12,
  parameter int CREDITS = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(CREDITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             cons_req,
  input logic             stall,
  input logic             out_valid,
  input logic [CNT_W-1:0] inflight
);

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (req_tag == (($past(req_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(req_tag) + TAG_W'(1))));

  // R3
  credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(CREDITS));

  // R3
  credit_block_chk: assert property (@(posedge clk) disable iff (rst)
    (inflight == CNT_W'(CREDITS)) |-> !req_ready);

  // R6
  stall_nopop_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !out_valid);

  // R7
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cons_req && !stall && !flush) |=> out_valid);

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !req_ready);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!cons_req || stall));

endmodule

bind ldq_stream ldq_stream_chk #(.DEPTH(DEPTH), .CREDITS(CREDITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_tag   (req_tag),
  .cons_req  (cons_req),
  .stall     (stall),
  .out_valid (out_valid),
  .inflight  (inflight)
);

// File: tb/sim_ldq_stream.sv
module sim_ldq_stream;

  localparam int CLK_P = 10;
  localparam int TW = 4;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [TW-1:0] req_tag;
  logic          ret_valid = 1'b0;
  logic [TW-1:0] ret_tag = '0;
  logic          ret_src = 1'b0;
  logic [DW-1:0] ret_data = '0;
  logic          cons_req = 1'b0;
  logic          stall;
  logic          out_valid;
  logic          out_src;
  logic [DW-1:0] out_data;

  int n_total = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ldq_stream u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_src(ret_src), .ret_data(ret_data),
    .cons_req(cons_req), .stall(stall),
    .out_valid(out_valid), .out_src(out_src), .out_data(out_data)
  );

  function automatic logic [DW-1:0] mk(int k);
    return {32'hA500_0000 + k, 32'h005A_0000 + k, 32'(k * 3), ~32'(k)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    flush = 1'b0; req_valid = 1'b0; ret_valid = 1'b0; cons_req = 1'b0;
  endtask

  // One cycle: request; checks ready and tag in the same cycle
  task automatic t_req(bit exp_rdy, int exp_tag, string r);
    @(negedge clk); quiet(); req_valid = 1'b1;
    #1;
    chk(req_ready == exp_rdy, r, "req_ready", DW'(req_ready), DW'(exp_rdy));
    if (exp_rdy) chk(req_tag == TW'(exp_tag), r, "req_tag", DW'(req_tag), DW'(exp_tag));
    @(posedge clk); #1;
  endtask

  // One idle cycle observing req_ready
  task automatic t_look(bit exp_rdy, string r);
    @(negedge clk); quiet();
    #1;
    chk(req_ready == exp_rdy, r, "req_ready", DW'(req_ready), DW'(exp_rdy));
    @(posedge clk); #1;
  endtask

  task automatic t_ret(int tag, bit src, logic [DW-1:0] d);
    @(negedge clk); quiet();
    ret_valid = 1'b1; ret_tag = TW'(tag); ret_src = src; ret_data = d;
    @(posedge clk); #1;
  endtask

  // One cycle consumer request; stall now, output after the edge
  task automatic t_pop(bit exp_stall, logic [DW-1:0] exp_d, bit exp_src, string r);
    @(negedge clk); quiet(); cons_req = 1'b1;
    #1;
    chk(stall == exp_stall, r, "stall", DW'(stall), DW'(exp_stall));
    @(posedge clk); #1;
    chk(out_valid == !exp_stall, r, "out_valid", DW'(out_valid), DW'(!exp_stall));
    if (!exp_stall) begin
      chk(out_data == exp_d, r, "out_data", out_data, exp_d);
      chk(out_src == exp_src, r, "out_src", DW'(out_src), DW'(exp_src));
    end
  endtask

  task automatic t_flush();
    @(negedge clk); quiet(); flush = 1'b1; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R9", "req_ready in flush cycle", DW'(req_ready), DW'(0));
    @(posedge clk); #1;
  endtask

  task automatic sc_reset();
    t_look(1'b1, "R1");
    t_pop(1'b1, '0, 1'b0, "R1");
  endtask

  task automatic sc_order();
    for (int k = 0; k < 4; k++) t_req(1'b1, k, "R2");
    t_pop(1'b1, '0, 1'b0, "R6");
    t_ret(2, 1'b0, mk(2));
    t_ret(0, 1'b1, mk(0));
    t_pop(1'b0, mk(0), 1'b1, "R7");
    t_pop(1'b1, '0, 1'b0, "R6 head unreturned");
    t_ret(1, 1'b0, mk(1));
    t_ret(3, 1'b1, mk(3));
    t_pop(1'b0, mk(1), 1'b0, "R5");
    t_pop(1'b0, mk(2), 1'b0, "R5");
    t_pop(1'b0, mk(3), 1'b1, "R5");
    t_pop(1'b1, '0, 1'b0, "R6 empty");
  endtask

  task automatic sc_credit();
    for (int k = 4; k < 12; k++) t_req(1'b1, k, "R2");
    t_look(1'b0, "R3");
    t_req(1'b0, 0, "R3");
    t_ret(0, 1'b0, mk(99));
    t_look(1'b0, "R11");
    t_pop(1'b1, '0, 1'b0, "R11");
    t_ret(4, 1'b0, mk(4));
    t_look(1'b1, "R3");
    for (int k = 5; k < 12; k++) t_ret(k, k[0], mk(k));
    for (int k = 4; k < 12; k++) t_pop(1'b0, mk(k), k[0], "R8");
  endtask

  task automatic sc_full();
    for (int k = 0; k < 12; k++) begin
      t_req(1'b1, k, "R2");
      t_ret(k, k[0], mk(k + 16));
    end
    t_look(1'b0, "R4");
    t_pop(1'b0, mk(16), 1'b0, "R4");
    t_look(1'b1, "R4");
    for (int k = 1; k < 12; k++) t_pop(1'b0, mk(k + 16), k[0], "R5");
  endtask

  task automatic sc_flush();
    t_req(1'b1, 0, "R2");
    t_req(1'b1, 1, "R2");
    t_ret(1, 1'b1, mk(41));
    t_flush();
    t_pop(1'b1, '0, 1'b0, "R9");
    for (int k = 2; k < 12; k++) begin
      t_req(1'b1, k, "R10");
      t_ret(k, k[0], mk(k + 50));
      t_pop(1'b0, mk(k + 50), k[0], "R10");
    end
    t_look(1'b0, "R10 stale slot held");
    t_ret(0, 1'b0, mk(77));
    t_pop(1'b1, '0, 1'b0, "R10 stale data dropped");
    t_look(1'b1, "R10 slot released");
    t_req(1'b1, 0, "R10");
    t_ret(0, 1'b1, mk(88));
    t_pop(1'b0, mk(88), 1'b1, "R10");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sc_reset();
    sc_order();
    sc_credit();
    sc_full();
    sc_flush();
    @(negedge clk); quiet();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule